// File: doc/BRIEF.md
# Two-Domain Sync and Reset Distributor

This block turns external synchronization events and a software reset request into control pulses for a receive datapath. The datapath runs in two clock domains: a front-end input clock and a back-end processing clock. Each domain has its own sync input. That input is brought into its domain through a two-flop synchronizer and reduced to its rising edge. A set of per-target enable bits then decides which datapath element gets a single-cycle strobe from that edge. On the front end the targets are the carrier oscillator, which takes a new phase offset and center frequency and has its accumulator feedback cleared, and the CIC decimation counters. On the back end the targets are the filter chain (halfband, FIR, resampler state machines and output FIFO), the AGC gain load, and the resampler oscillator load.

A software reset request becomes a reset pulse exactly `RST_LEN` (10) cycles wide in each domain, timed by that domain's own clock. This flushes every enable still travelling through the pipelines. The same stretcher on the front end can also be triggered by the front-end sync edge when the filter-reset enable is set. A request that arrives while a stretch is running loads the counter again, so the pulse is extended and never cut short.

For multi-device alignment, every front-end sync edge also produces a master sync output. It is held for `MSYNC_LEN` (4) input-clock cycles, so that the slower back-end clock of every receiving device can capture it. The master sync input may be wired back to this block's own master output. It is synchronized in both domains, and its rising edge produces a one-cycle sync output. A selection bit decides which domain's clock times that pulse.

Top module: `sync_reset_dist`

## Requirements
- R1: A rising edge on `fe_sync_in` with `cfg_car_en`=1 gives exactly one high cycle of `fe_carrier_load`. The strobe is high in the third front-end clock cycle after the input rises (two synchronizer stages plus the strobe register). It stays low when `cfg_car_en`=0.
- R2: A rising edge on `fe_sync_in` gives exactly one high cycle of `fe_cic_update` when `cfg_cic_en`=1, and none when it is 0.
- R3: A rising edge on `be_sync_in` gives exactly one high cycle of `be_filt_clr` when `cfg_filt_rst_en`=1, and none when it is 0.
- R4: A rising edge on `be_sync_in` gives exactly one high cycle of `be_agc_load` when `cfg_agc_en`=1, and none when it is 0.
- R5: A rising edge on `be_sync_in` gives exactly one high cycle of `be_rsmp_load` when `cfg_rsmp_en`=1, and none when it is 0.
- R6: One rising edge of `sw_reset_req` makes `fe_reset_out` high for exactly 10 front-end cycles and `be_reset_out` high for exactly 10 back-end cycles.
- R7: A front-end sync edge with `cfg_filt_rst_en`=1 makes `fe_reset_out` high for exactly 10 front-end cycles. With `cfg_filt_rst_en`=0 it leaves `fe_reset_out` low.
- R8: A new reset trigger during a running stretch restarts the count. Two software requests rising 6 front-end cycles apart give 16 high front-end cycles on `fe_reset_out`.
- R9: A sync input held high for many cycles produces only one strobe per enabled target. Strobes come from edges, not levels.
- R10: Every front-end sync edge drives `msync_out` high for exactly 4 front-end cycles, whatever the enables are. It starts one cycle after the cycle in which `fe_carrier_load` would be high.
- R11: A rising edge on `msync_in` gives one cycle of `sync_out`. With `cfg_sync_out_sel`=0 that cycle is timed by `fe_clk`, and with `cfg_sync_out_sel`=1 it is timed by `be_clk`.
- R12: While a domain's reset is low, and after it is released with no input activity, every output of that domain is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fe_clk | input | 1 | Front-end (input sample) clock |
| fe_rst_n | input | 1 | Front-end synchronous reset, active low |
| be_clk | input | 1 | Back-end (processing) clock |
| be_rst_n | input | 1 | Back-end synchronous reset, active low |
| fe_sync_in | input | 1 | Front-end sync event, asynchronous |
| be_sync_in | input | 1 | Back-end sync event, asynchronous |
| msync_in | input | 1 | Master sync input, may loop back from msync_out |
| sw_reset_req | input | 1 | Software reset request, asynchronous |
| cfg_sync_out_sel | input | 1 | 0: sync_out timed by fe_clk, 1: by be_clk |
| cfg_car_en | input | 1 | Front-end sync loads the carrier oscillator |
| cfg_cic_en | input | 1 | Front-end sync resets the CIC decimation counters |
| cfg_filt_rst_en | input | 1 | Sync resets the filter chain / stretches front-end reset |
| cfg_agc_en | input | 1 | Back-end sync loads a new AGC gain |
| cfg_rsmp_en | input | 1 | Back-end sync loads the resampler oscillator |
| fe_carrier_load | output | 1 | One-cycle carrier load and feedback clear |
| fe_cic_update | output | 1 | One-cycle CIC counter reset |
| fe_reset_out | output | 1 | Stretched front-end reset |
| be_filt_clr | output | 1 | One-cycle filter chain and FIFO clear |
| be_agc_load | output | 1 | One-cycle AGC gain load |
| be_rsmp_load | output | 1 | One-cycle resampler oscillator load |
| be_reset_out | output | 1 | Stretched back-end reset |
| sync_out | output | 1 | One-cycle sync pulse in the selected domain |
| msync_out | output | 1 | Master sync output, 4 front-end cycles wide |

## Verification
On every cycle, the assertions check the following. Each load strobe lasts a single cycle. A strobe is only ever issued with its enable set. No stretched reset falls before it has been high for the full ten cycles of its domain. The master output follows a carrier strobe by one cycle, and a front-end-timed sync output lasts one cycle. Only the bench scenarios can show the counts and the exact timing. These include a strobe appearing at all for an enabled target and staying away for a disabled one, the three-cycle front-end latency, and a held input yielding a single strobe. They also include the extension of the reset to 16 cycles when a second request arrives, and the domain selection of `sync_out` through the looped-back master path.

// File: rtl/srd_pkg.sv
// Package: shared sizes and target indices for the sync/reset distributor.
// Assumes: each domain has three strobe targets; indices fix the bit order
// of the per-domain strobe vectors.
package srd_pkg;
    localparam int NUM_TGT     = 3;   // strobe targets per domain
    localparam int SYNC_STAGES = 2;   // synchronizer depth
    // front-end target slots
    localparam int FE_CAR = 0;
    localparam int FE_CIC = 1;
    localparam int FE_EVT = 2;        // unconditional event, feeds master output
    // back-end target slots
    localparam int BE_FILT = 0;
    localparam int BE_AGC  = 1;
    localparam int BE_RSMP = 2;
endpackage

// File: rtl/srd_edge_sync.sv
// Module: srd_edge_sync
// Brings an asynchronous level into the clk domain through STAGES flops and
// flags its rising edge for one cycle (combinational from registered state).
// Assumes: the input stays high or low for at least one clk period.
module srd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic [STAGES:0] shreg;

    // Shift the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], d};
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/srd_stretch.sv
// Module: srd_stretch
// Holds its output high for LEN cycles after a trigger; a trigger during a
// running stretch reloads the counter so the pulse is extended, never cut.
// Assumes: LEN >= 1.
module srd_stretch #(
    parameter int LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] cnt;

    // Load on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (trig)       cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign pulse = (cnt != '0);
endmodule

// File: rtl/srd_domain.sv
// Module: srd_domain
// One clock domain's distributor: synchronizes the sync input and the reset
// request, issues one registered strobe per enabled target on a sync edge,
// and stretches reset on a request or on an enabled sync edge.
// Assumes: tgt_en and sync_rst_en are quasi-static configuration.
module srd_domain #(
    parameter int NT      = 3,
    parameter int STAGES  = 2,
    parameter int RST_LEN = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_in,
    input  logic          rst_req_in,
    input  logic [NT-1:0] tgt_en,
    input  logic          sync_rst_en,
    output logic [NT-1:0] strobe,
    output logic          rst_out
);
    logic sync_rise;
    logic req_rise;

    srd_edge_sync #(.STAGES(STAGES)) u_sync_edge (
        .clk(clk), .rst_n(rst_n), .d(sync_in), .rise(sync_rise)
    );

    srd_edge_sync #(.STAGES(STAGES)) u_req_edge (
        .clk(clk), .rst_n(rst_n), .d(rst_req_in), .rise(req_rise)
    );

    for (genvar gi = 0; gi < NT; gi++) begin : g_tgt
        // Register one strobe for this target on an enabled sync edge.
        always_ff @(posedge clk) begin
            if (!rst_n) strobe[gi] <= 1'b0;
            else        strobe[gi] <= sync_rise & tgt_en[gi];
        end
    end

    srd_stretch #(.LEN(RST_LEN)) u_rst_stretch (
        .clk(clk), .rst_n(rst_n),
        .trig(req_rise | (sync_rise & sync_rst_en)),
        .pulse(rst_out)
    );
endmodule

// File: rtl/srd_sync_out.sv
// Module: srd_sync_out
// Receives the master sync input in both domains and produces a one-cycle
// sync_out pulse timed by the domain chosen with sel.
// Assumes: sel changes only while the master path is idle; msync_in is at
// least one period of the slower clock wide.
module srd_sync_out #(
    parameter int STAGES = 2
) (
    input  logic fe_clk,
    input  logic fe_rst_n,
    input  logic be_clk,
    input  logic be_rst_n,
    input  logic sel,
    input  logic msync_in,
    output logic sync_out
);
    logic fe_rise, be_rise;
    logic fe_pulse, be_pulse;

    srd_edge_sync #(.STAGES(STAGES)) u_fe_edge (
        .clk(fe_clk), .rst_n(fe_rst_n), .d(msync_in), .rise(fe_rise)
    );

    srd_edge_sync #(.STAGES(STAGES)) u_be_edge (
        .clk(be_clk), .rst_n(be_rst_n), .d(msync_in), .rise(be_rise)
    );

    // Front-end timed pulse.
    always_ff @(posedge fe_clk) begin
        if (!fe_rst_n) fe_pulse <= 1'b0;
        else           fe_pulse <= fe_rise & ~sel;
    end

    // Back-end timed pulse.
    always_ff @(posedge be_clk) begin
        if (!be_rst_n) be_pulse <= 1'b0;
        else           be_pulse <= be_rise & sel;
    end

    assign sync_out = sel ? be_pulse : fe_pulse;
endmodule

// File: rtl/sync_reset_dist.sv
// Module: sync_reset_dist (top)
// Distributes sync strobes and stretched resets into the front-end and
// back-end domains, and drives the master sync and sync outputs.
// Assumes: all event inputs are asynchronous and wider than one period of
// the slower clock; enables are static while events are in flight.
module sync_reset_dist
    import srd_pkg::*;
#(
    parameter int RST_LEN   = 10,
    parameter int MSYNC_LEN = 4
) (
    input  logic fe_clk,
    input  logic fe_rst_n,
    input  logic be_clk,
    input  logic be_rst_n,
    input  logic fe_sync_in,
    input  logic be_sync_in,
    input  logic msync_in,
    input  logic sw_reset_req,
    input  logic cfg_sync_out_sel,
    input  logic cfg_car_en,
    input  logic cfg_cic_en,
    input  logic cfg_filt_rst_en,
    input  logic cfg_agc_en,
    input  logic cfg_rsmp_en,
    output logic fe_carrier_load,
    output logic fe_cic_update,
    output logic fe_reset_out,
    output logic be_filt_clr,
    output logic be_agc_load,
    output logic be_rsmp_load,
    output logic be_reset_out,
    output logic sync_out,
    output logic msync_out
);
    logic [NUM_TGT-1:0] fe_en, fe_stb;
    logic [NUM_TGT-1:0] be_en, be_stb;

    // Gather the per-target enables into slot order.
    always_comb begin
        fe_en          = '0;
        fe_en[FE_CAR]  = cfg_car_en;
        fe_en[FE_CIC]  = cfg_cic_en;
        fe_en[FE_EVT]  = 1'b1;
        be_en          = '0;
        be_en[BE_FILT] = cfg_filt_rst_en;
        be_en[BE_AGC]  = cfg_agc_en;
        be_en[BE_RSMP] = cfg_rsmp_en;
    end

    srd_domain #(.NT(NUM_TGT), .STAGES(SYNC_STAGES), .RST_LEN(RST_LEN)) u_fe (
        .clk(fe_clk), .rst_n(fe_rst_n),
        .sync_in(fe_sync_in), .rst_req_in(sw_reset_req),
        .tgt_en(fe_en), .sync_rst_en(cfg_filt_rst_en),
        .strobe(fe_stb), .rst_out(fe_reset_out)
    );

    srd_domain #(.NT(NUM_TGT), .STAGES(SYNC_STAGES), .RST_LEN(RST_LEN)) u_be (
        .clk(be_clk), .rst_n(be_rst_n),
        .sync_in(be_sync_in), .rst_req_in(sw_reset_req),
        .tgt_en(be_en), .sync_rst_en(1'b0),
        .strobe(be_stb), .rst_out(be_reset_out)
    );

    srd_stretch #(.LEN(MSYNC_LEN)) u_msync (
        .clk(fe_clk), .rst_n(fe_rst_n),
        .trig(fe_stb[FE_EVT]), .pulse(msync_out)
    );

    srd_sync_out #(.STAGES(SYNC_STAGES)) u_sync_out (
        .fe_clk(fe_clk), .fe_rst_n(fe_rst_n),
        .be_clk(be_clk), .be_rst_n(be_rst_n),
        .sel(cfg_sync_out_sel), .msync_in(msync_in),
        .sync_out(sync_out)
    );

    assign fe_carrier_load = fe_stb[FE_CAR];
    assign fe_cic_update   = fe_stb[FE_CIC];
    assign be_filt_clr     = be_stb[BE_FILT];
    assign be_agc_load     = be_stb[BE_AGC];
    assign be_rsmp_load    = be_stb[BE_RSMP];
endmodule

// File: rtl/srd_checker.sv
// Module: srd_checker
// Cycle-by-cycle properties of sync_reset_dist, attached with bind.
// Assumes: the enable inputs are static while a strobe is in flight.
module srd_checker #(
    parameter int RST_LEN = 10
) (
    input logic fe_clk,
    input logic fe_rst_n,
    input logic be_clk,
    input logic be_rst_n,
    input logic cfg_agc_en,
    input logic cfg_sync_out_sel,
    input logic fe_carrier_load,
    input logic fe_cic_update,
    input logic fe_reset_out,
    input logic be_filt_clr,
    input logic be_agc_load,
    input logic be_rsmp_load,
    input logic be_reset_out,
    input logic sync_out,
    input logic msync_out
);
    logic [7:0] fe_run, be_run;

    // Count consecutive high cycles of the front-end reset.
    always_ff @(posedge fe_clk) begin
        if (!fe_rst_n)         fe_run <= '0;
        else if (!fe_reset_out) fe_run <= '0;
        else if (fe_run != 8'hFF) fe_run <= fe_run + 1'b1;
    end

    // Count consecutive high cycles of the back-end reset.
    always_ff @(posedge be_clk) begin
        if (!be_rst_n)         be_run <= '0;
        else if (!be_reset_out) be_run <= '0;
        else if (be_run != 8'hFF) be_run <= be_run + 1'b1;
    end

    assert_car_single_R1: assert property (@(posedge fe_clk) disable iff (!fe_rst_n)
        fe_carrier_load |=> !fe_carrier_load);
    assert_cic_single_R2: assert property (@(posedge fe_clk) disable iff (!fe_rst_n)
        fe_cic_update |=> !fe_cic_update);
    assert_filt_single_R3: assert property (@(posedge be_clk) disable iff (!be_rst_n)
        be_filt_clr |=> !be_filt_clr);
    assert_agc_enabled_R4: assert property (@(posedge be_clk) disable iff (!be_rst_n)
        be_agc_load |-> $past(cfg_agc_en));
    assert_rsmp_single_R5: assert property (@(posedge be_clk) disable iff (!be_rst_n)
        be_rsmp_load |=> !be_rsmp_load);
    assert_fe_rst_len_R6: assert property (@(posedge fe_clk) disable iff (!fe_rst_n)
        $fell(fe_reset_out) |-> (fe_run >= 8'(RST_LEN)));
    assert_be_rst_len_R6: assert property (@(posedge be_clk) disable iff (!be_rst_n)
        $fell(be_reset_out) |-> (be_run >= 8'(RST_LEN)));
    assert_msync_follows_R10: assert property (@(posedge fe_clk) disable iff (!fe_rst_n)
        fe_carrier_load |=> msync_out);
    assert_syncout_fe_single_R11: assert property (@(posedge fe_clk) disable iff (!fe_rst_n)
        (!cfg_sync_out_sel && sync_out) |=> !sync_out);
endmodule

bind sync_reset_dist srd_checker #(.RST_LEN(RST_LEN)) u_chk (.*);

// File: tb/tb_sync_reset_dist.sv
module tb_sync_reset_dist;
    logic fe_clk = 0, be_clk = 0;
    logic fe_rst_n = 0, be_rst_n = 0;
    logic fe_sync_in = 0, be_sync_in = 0, sw_reset_req = 0;
    logic msync_in;
    logic cfg_sync_out_sel = 0, cfg_car_en = 0, cfg_cic_en = 0;
    logic cfg_filt_rst_en = 0, cfg_agc_en = 0, cfg_rsmp_en = 0;
    logic fe_carrier_load, fe_cic_update, fe_reset_out;
    logic be_filt_clr, be_agc_load, be_rsmp_load, be_reset_out;
    logic sync_out, msync_out;

    int total = 0, bad = 0;
    bit done = 0, clr = 0;
    int c_car, c_cic, c_fers, c_ms, c_sofe, c_filt, c_agc, c_rsmp, c_bers, c_sobe;

    always #2.5 fe_clk = ~fe_clk;   // 200 MHz
    always #4   be_clk = ~be_clk;

    assign msync_in = msync_out;    // master loopback

    sync_reset_dist dut (.*);

    // Per-domain high-cycle counters, sampled on the falling edge.
    always @(negedge fe_clk) begin
        if (clr) begin
            c_car <= 0; c_cic <= 0; c_fers <= 0; c_ms <= 0; c_sofe <= 0;
        end else begin
            c_car  <= c_car  + int'(fe_carrier_load);
            c_cic  <= c_cic  + int'(fe_cic_update);
            c_fers <= c_fers + int'(fe_reset_out);
            c_ms   <= c_ms   + int'(msync_out);
            c_sofe <= c_sofe + int'(sync_out);
        end
    end
    always @(negedge be_clk) begin
        if (clr) begin
            c_filt <= 0; c_agc <= 0; c_rsmp <= 0; c_bers <= 0; c_sobe <= 0;
        end else begin
            c_filt <= c_filt + int'(be_filt_clr);
            c_agc  <= c_agc  + int'(be_agc_load);
            c_rsmp <= c_rsmp + int'(be_rsmp_load);
            c_bers <= c_bers + int'(be_reset_out);
            c_sobe <= c_sobe + int'(sync_out);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic clear_counts();
        @(negedge fe_clk) clr = 1;
        repeat (2) @(negedge be_clk);
        @(negedge fe_clk) clr = 0;
    endtask

    task automatic set_en(input logic [4:0] en, input logic sel);
        cfg_car_en = en[0]; cfg_cic_en = en[1]; cfg_filt_rst_en = en[2];
        cfg_agc_en = en[3]; cfg_rsmp_en = en[4]; cfg_sync_out_sel = sel;
    endtask

    task automatic pulse_syncs(input int hold);
        @(negedge fe_clk) begin fe_sync_in = 1; be_sync_in = 1; end
        repeat (hold) @(negedge fe_clk);
        fe_sync_in = 0; be_sync_in = 0;
        repeat (40) @(negedge fe_clk);
    endtask

    // Enables {rsmp, agc, filt, cic, car} and expected fe_reset_out cycles.
    localparam logic [12:0] VEC [7] = '{
        {5'b00001, 8'd0}, {5'b00010, 8'd0}, {5'b00100, 8'd10},
        {5'b01000, 8'd0}, {5'b10000, 8'd0}, {5'b11111, 8'd10},
        {5'b00000, 8'd0}
    };

    initial begin
        repeat (100000) @(posedge fe_clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R12: outputs low during reset and after release
        repeat (6) @(negedge fe_clk);
        chk("R12 in reset", int'({fe_carrier_load, fe_cic_update, fe_reset_out,
            be_filt_clr, be_agc_load, be_rsmp_load, be_reset_out, sync_out, msync_out}), 0);
        fe_rst_n = 1; be_rst_n = 1;
        clear_counts();
        repeat (20) @(negedge fe_clk);
        chk("R12 idle after reset", c_car + c_cic + c_fers + c_ms + c_sofe +
            c_filt + c_agc + c_rsmp + c_bers + c_sobe, 0);

        // Table walk: R1 R2 R3 R4 R5 R7 R10 R11
        for (int i = 0; i < 7; i++) begin
            logic [4:0] en;
            int er;
            en = VEC[i][12:8];
            er = int'(VEC[i][7:0]);
            set_en(en, 1'b0);
            clear_counts();
            pulse_syncs(8);
            chk("R1 carrier count",  c_car,  int'(en[0]));
            chk("R2 cic count",      c_cic,  int'(en[1]));
            chk("R3 filter clear",   c_filt, int'(en[2]));
            chk("R4 agc load",       c_agc,  int'(en[3]));
            chk("R5 resampler load", c_rsmp, int'(en[4]));
            chk("R7 fe sync reset",  c_fers, er);
            chk("R10 msync width",   c_ms,   4);
            chk("R11 sync_out fe",   c_sofe, 1);
        end

        // R1: latency of three front-end edges
        set_en(5'b00001, 1'b0);
        clear_counts();
        @(negedge fe_clk) fe_sync_in = 1;
        @(negedge fe_clk);
        @(negedge fe_clk) chk("R1 latency N2", int'(fe_carrier_load), 0);
        @(negedge fe_clk) chk("R1 latency N3", int'(fe_carrier_load), 1);
        @(negedge fe_clk) chk("R1 latency N4", int'(fe_carrier_load), 0);
        fe_sync_in = 0;
        repeat (30) @(negedge fe_clk);

        // R9: held sync input yields one strobe
        set_en(5'b01001, 1'b0);
        clear_counts();
        pulse_syncs(40);
        chk("R9 held fe", c_car, 1);
        chk("R9 held be", c_agc, 1);

        // R6: software reset width in both domains
        set_en(5'b00000, 1'b0);
        clear_counts();
        @(negedge fe_clk) sw_reset_req = 1;
        repeat (3) @(negedge fe_clk);
        sw_reset_req = 0;
        repeat (40) @(negedge fe_clk);
        chk("R6 fe reset width", c_fers, 10);
        chk("R6 be reset width", c_bers, 10);

        // R8: second request 6 cycles later extends the pulse
        clear_counts();
        @(negedge fe_clk) sw_reset_req = 1;
        repeat (2) @(negedge fe_clk);
        sw_reset_req = 0;
        repeat (4) @(negedge fe_clk);
        sw_reset_req = 1;
        repeat (2) @(negedge fe_clk);
        sw_reset_req = 0;
        repeat (40) @(negedge fe_clk);
        chk("R8 fe restart", c_fers, 16);
        chk_rng("R8 be restart", c_bers, 12, 15);

        // R11: sync_out timed by the back-end clock
        set_en(5'b00000, 1'b1);
        clear_counts();
        pulse_syncs(8);
        chk("R11 sync_out be", c_sobe, 1);
        chk("R10 msync with enables off", c_ms, 4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule